// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the debugger side of a two-wire debug link. It generates the serial debug clock from the system clock through a programmable divider, drives a split data line (output value, output enable, input value) that meets a bidirectional pad outside the block, and carries out one command at a time. There are three commands. A line reset holds the data line high for fifty clocks. A switch sequence emits the sixteen-bit pattern that moves a dual-protocol port from JTAG to serial-wire operation. A register transaction addresses one debug-port or access-port register.

A transaction runs in a fixed order. The host sends an eight-bit framed request and then releases the line for a turnaround clock. It samples a three-bit acknowledge. If the acknowledge is OK, a 33-bit data phase follows, driven by the target on a read and by the host on a write. The engine handles both line turnarounds and both parity bits. It reports the acknowledge code, the read word and a data parity error with a single-cycle done pulse.

The engine enforces packet alignment in hardware. After a system reset or a line reset, the only transaction it accepts is a debug-port read of register 0, the identification register. Any other transaction is refused without clocking the line. Retry after WAIT, access-port address sequencing and memory loading belong to the logic above this block.

Top module: `swd_host_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: `busy`=0, `done`=0, `swclk`=0, `swdio_oe`=0, `ack_code`=000, `par_err`=0, `rd_data`=0.
- R2: `swclk` stays low while idle. While busy it toggles every max(`clk_div`,1) system clocks, so its period is twice that. The host changes `swdio_o`/`swdio_oe` only when `swclk` falls or when a command is accepted with `swclk` low, and it samples `swdio_i` on the rising edge of `swclk`.
- R3: The request occupies the first 8 serial clocks, host driven, in this order: 1, `req_ap`, `req_rnw`, `req_addr[0]`, `req_addr[1]`, parity, 0, 1. The parity bit is 1 when an odd number of `req_ap`, `req_rnw`, `req_addr[1:0]` are 1.
- R4: Serial clock 9 is a turnaround with the host released. Clocks 10 to 12 carry the acknowledge, host released, LSB first into `ack_code[0]`, `[1]`, `[2]`. OK=001, WAIT=010, FAULT=100.
- R5: On a read with an OK acknowledge, clocks 13 to 44 carry the 32 data bits LSB first and clock 45 carries their parity, all target driven. Clock 46 is a turnaround. `rd_data` holds the word at `done`. The transaction takes 46 clocks.
- R6: `par_err` is 1 after a read whose received parity bit differs from the XOR of the 32 received bits, and 0 otherwise. Every accepted command clears it, and writes leave it 0.
- R7: On a write with an OK acknowledge, clock 13 is a turnaround. Clocks 14 to 45 carry `wr_data` LSB first, host driven, and clock 46 carries the XOR of `wr_data`. The transaction takes 46 clocks, and the line is released once `done` is given.
- R8: Any acknowledge other than 001 skips the data phase. One released turnaround clock follows, giving 13 clocks in all, and then `done` with the received code. `rd_data` keeps its previous value.
- R9: `cmd_op`=1 drives `swdio_o`=1 with `swdio_oe`=1 for exactly 50 serial clocks.
- R10: `cmd_op`=2 sends 16 host-driven bits of 16'hE79E, LSB first.
- R11: After reset or a line reset, a transaction command (`cmd_op` 0 or 3) that is not a debug-port read of address 0 is refused. It gets `done` in the next cycle with `ack_code`=000, and no `swclk` edges occur. The refusal rule stays in force until an identification read is accepted.
- R12: `done` is a one-cycle pulse. `cmd_start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Half period of swclk in system clocks (0 acts as 1) |
| cmd_start | input | 1 | Start pulse, taken when idle |
| cmd_op | input | 2 | 0/3 transaction, 1 line reset, 2 switch sequence |
| req_ap | input | 1 | 1 selects an access-port register |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 |
| wr_data | input | 32 | Write word |
| swdio_i | input | 1 | Data line value from the pad |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Last word read |
| ack_code | output | 3 | Received acknowledge, first bit in bit 0 |
| par_err | output | 1 | Read data parity mismatch |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drive enable for the data line |

## Verification
The bench plays the target. It logs the host's drive state at every rising `swclk` and feeds acknowledge and read bits at every falling edge, so an off-by-one in the turnaround placement shows up at once. A design missing the write turnaround would put its first data bit on clock 13. A design that runs the data phase after WAIT or FAULT would report 46 clocks instead of 13. A request parity or bit-order error garbles the logged request. Received parity is corrupted on purpose to exercise the error flag, and refused commands after a line reset must produce no clock edges. A start pulse sent in the middle of a transaction must leave that transaction's bit stream unchanged.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    localparam int DATA_W      = 32;
    localparam int CNT_W       = 6;
    localparam int REQ_LEN     = 8;
    localparam int ACK_LEN     = 3;
    localparam int DPHASE_LEN  = DATA_W + 1;
    localparam int LRST_LEN    = 50;
    localparam int JSW_LEN     = 16;
    localparam logic [JSW_LEN-1:0] JSW_PATTERN = 16'hE79E;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] OP_LRST = 2'd1;
    localparam logic [1:0] OP_JSW  = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_TRN1,
        ST_ACK,
        ST_TRN2,
        ST_WDATA,
        ST_RDATA,
        ST_TRN3,
        ST_LRST,
        ST_JSW
    } seq_state_e;

    typedef struct packed {
        logic       ap;
        logic       rd;
        logic [1:0] addr;
    } swd_req_t;

    function automatic logic req_parity(input swd_req_t r);
        return r.ap ^ r.rd ^ r.addr[0] ^ r.addr[1];
    endfunction

    function automatic logic req_bit(input swd_req_t r, input logic [2:0] idx);
        logic b;
        case (idx)
            3'd0:    b = 1'b1;
            3'd1:    b = r.ap;
            3'd2:    b = r.rd;
            3'd3:    b = r.addr[0];
            3'd4:    b = r.addr[1];
            3'd5:    b = req_parity(r);
            3'd6:    b = 1'b0;
            default: b = 1'b1;
        endcase
        return b;
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(input seq_state_e s);
        logic [CNT_W-1:0] n;
        case (s)
            ST_REQ:             n = CNT_W'(REQ_LEN);
            ST_ACK:             n = CNT_W'(ACK_LEN);
            ST_WDATA, ST_RDATA: n = CNT_W'(DPHASE_LEN);
            ST_LRST:            n = CNT_W'(LRST_LEN);
            ST_JSW:             n = CNT_W'(JSW_LEN);
            default:            n = CNT_W'(1);
        endcase
        return n;
    endfunction

    function automatic logic is_id_read(input swd_req_t r);
        return !r.ap && r.rd && (r.addr == 2'b00);
    endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             swclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    assign limit = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick  = (cnt == limit - DIV_W'(1));
    assign rise  = run && tick && !swclk;
    assign fall  = run && tick && swclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            swclk <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            swclk <= !swclk;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    AST_CLK_PARKED_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> !swclk); // R2

endmodule

// File: rtl/swd_bit_seq.sv
module swd_bit_seq
    import swd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  swd_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        ack,
    output logic              par_err,
    output logic              dout,
    output logic              dout_en
);
    seq_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    swd_req_t          req_q;
    logic [DATA_W-1:0] wdata_q;
    logic              need_id;
    logic              last_bit;
    logic              ack_ok;
    logic              is_xfer;

    assign busy     = (state != ST_IDLE);
    assign last_bit = (bitcnt == phase_len(state) - CNT_W'(1));
    assign ack_ok   = (ack == ACK_OK);
    assign is_xfer  = (op != OP_LRST) && (op != OP_JSW);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            req_q   <= '0;
            wdata_q <= '0;
            need_id <= 1'b1;
            done    <= 1'b0;
            rdata   <= '0;
            ack     <= '0;
            par_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    bitcnt  <= '0;
                    ack     <= '0;
                    par_err <= 1'b0;
                    if (op == OP_LRST) begin
                        state   <= ST_LRST;
                        need_id <= 1'b1;
                    end else if (op == OP_JSW) begin
                        state <= ST_JSW;
                    end else if (need_id && !is_id_read(req)) begin
                        done <= 1'b1;
                    end else begin
                        state   <= ST_REQ;
                        need_id <= 1'b0;
                        req_q   <= req;
                        wdata_q <= wdata;
                    end
                end
            end else begin
                if (rise) begin
                    if (state == ST_ACK) begin
                        ack <= {din, ack[2:1]};
                    end else if (state == ST_RDATA) begin
                        if (bitcnt < CNT_W'(DATA_W))
                            rdata <= {din, rdata[DATA_W-1:1]};
                        else
                            par_err <= din ^ (^rdata);
                    end
                end
                if (fall) begin
                    if (!last_bit) begin
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else begin
                        bitcnt <= '0;
                        case (state)
                            ST_REQ:   state <= ST_TRN1;
                            ST_TRN1:  state <= ST_ACK;
                            ST_ACK:   state <= (ack_ok && req_q.rd) ? ST_RDATA : ST_TRN2;
                            ST_TRN2: begin
                                if (ack_ok && !req_q.rd) begin
                                    state <= ST_WDATA;
                                end else begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end
                            end
                            ST_RDATA: state <= ST_TRN3;
                            default: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end

    always_comb begin
        dout    = 1'b0;
        dout_en = 1'b0;
        case (state)
            ST_REQ: begin
                dout_en = 1'b1;
                dout    = req_bit(req_q, bitcnt[2:0]);
            end
            ST_WDATA: begin
                dout_en = 1'b1;
                dout    = (bitcnt < CNT_W'(DATA_W)) ? wdata_q[bitcnt[4:0]] : ^wdata_q;
            end
            ST_LRST: begin
                dout_en = 1'b1;
                dout    = 1'b1;
            end
            ST_JSW: begin
                dout_en = 1'b1;
                dout    = JSW_PATTERN[bitcnt[3:0]];
            end
            default: begin
                dout    = 1'b0;
                dout_en = 1'b0;
            end
        endcase
    end

    AST_GUARD_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && need_id && is_xfer && !is_id_read(req))
        |=> (done && !busy && ack == 3'b000)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_NO_PARERR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA) |-> !par_err); // R6

    AST_NONOK_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack_ok && state == ST_TRN2 && fall) |=> !busy); // R8

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              req_ap,
    input  logic              req_rnw,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              swdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        ack_code,
    output logic              par_err,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe
);
    logic     rise_ev;
    logic     fall_ev;
    swd_req_t req_in;

    assign req_in = '{ap: req_ap, rd: req_rnw, addr: req_addr};

    swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half_div (clk_div),
        .swclk    (swclk),
        .rise     (rise_ev),
        .fall     (fall_ev)
    );

    swd_bit_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (cmd_start),
        .op      (cmd_op),
        .req     (req_in),
        .wdata   (wr_data),
        .rise    (rise_ev),
        .fall    (fall_ev),
        .din     (swdio_i),
        .busy    (busy),
        .done    (done),
        .rdata   (rd_data),
        .ack     (ack_code),
        .par_err (par_err),
        .dout    (swdio_o),
        .dout_en (swdio_oe)
    );

    AST_DIO_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe))); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!swdio_oe && !swclk)); // R7

endmodule

// File: tb/swd_host_engine_test.sv
`timescale 1ns/1ps
module swd_host_engine_test;
    localparam int DIV_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [DIV_W-1:0] clk_div = 8'd1;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        req_ap = 1'b0;
    logic        req_rnw = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        swdio_i = 1'b0;
    logic        busy, done, par_err, swclk, swdio_o, swdio_oe;
    logic [31:0] rd_data;
    logic [2:0]  ack_code;

    swd_host_engine #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst(rst), .clk_div(clk_div), .cmd_start(cmd_start),
        .cmd_op(cmd_op), .req_ap(req_ap), .req_rnw(req_rnw), .req_addr(req_addr),
        .wr_data(wr_data), .swdio_i(swdio_i), .busy(busy), .done(done),
        .rd_data(rd_data), .ack_code(ack_code), .par_err(par_err),
        .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe)
    );

    always #2.5 clk = ~clk;

    int      n_chk = 0;
    int      n_fail = 0;
    bit      ended = 0;
    logic [63:0] h_oe, h_o;
    logic    tgt [0:63];
    int      rcount = 0;
    realtime t0, t1;
    logic [31:0] exp_rdata = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // target model: log host drive at rising swclk, present target bits after falling swclk
    initial forever begin
        @(posedge swclk);
        if (rcount < 64) begin
            h_oe[rcount] = swdio_oe;
            h_o[rcount]  = swdio_o;
        end
        if (rcount == 0) t0 = $realtime;
        if (rcount == 1) t1 = $realtime;
        rcount++;
    end

    initial forever begin
        @(negedge swclk);
        swdio_i = tgt[(rcount < 64) ? rcount : 63];
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual=%0h expected=%0h", 0, 1);
        summary();
    end

    function automatic logic exp_req_bit(input logic ap, input logic rd,
                                         input logic [1:0] a, input int i);
        logic [7:0] f;
        f = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
        return f[i];
    endfunction

    task automatic issue(input logic [1:0] op, input logic ap, input logic rd,
                         input logic [1:0] a, input logic [31:0] wd);
        @(negedge clk);
        rcount   = 0;
        cmd_op   = op;
        req_ap   = ap;
        req_rnw  = rd;
        req_addr = a;
        wr_data  = wd;
        cmd_start = 1'b1;
        @(posedge clk);
        #1 cmd_start = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        bit ok;
        ok = 0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (done) begin
                ok = 1;
                break;
            end
        end
        chk(ok, rq, "done seen", ok, 1);
    endtask

    task automatic do_xfer(input logic ap, input logic rd, input logic [1:0] a,
                           input logic [31:0] wd, input logic [2:0] ak,
                           input logic [31:0] rdv, input bit badpar,
                           input logic [DIV_W-1:0] dv);
        int mis;
        bit okack;
        int eff;
        okack = (ak == 3'b001);
        eff = (dv == 0) ? 1 : int'(dv);
        clk_div = dv;
        for (int i = 0; i < 64; i++) tgt[i] = 1'b0;
        for (int i = 0; i < 3; i++) tgt[9 + i] = ak[i];
        if (rd && okack) begin
            for (int i = 0; i < 32; i++) tgt[12 + i] = rdv[i];
            tgt[44] = (^rdv) ^ badpar;
        end
        issue(2'd0, ap, rd, a, wd);
        wait_done("R12");
        // R4: acknowledge code
        chk(ack_code == ak, "R4", "ack_code", ack_code, ak);
        if (rd && okack) exp_rdata = rdv;
        chk(rd_data == exp_rdata, (rd && okack) ? "R5" : "R8", "rd_data", rd_data, exp_rdata);
        chk(par_err == (rd && okack && badpar), "R6", "par_err", par_err, rd && okack && badpar);
        chk(rcount == (okack ? 46 : 13), okack ? (rd ? "R5" : "R7") : "R8",
            "serial clock count", rcount, okack ? 46 : 13);
        mis = 0;
        for (int i = 0; i < 8; i++)
            if (!h_oe[i] || h_o[i] !== exp_req_bit(ap, rd, a, i)) mis++;
        chk(mis == 0, "R3", "request bit errors", mis, 0);
        chk(h_oe[11:8] == 4'b0000, "R4", "turnaround/ack drive", h_oe[11:8], 0);
        if (okack && rd) begin
            chk(h_oe[45:12] == '0, "R5", "host drive in read data", h_oe[45:12], 0);
        end else if (okack) begin
            mis = 0;
            if (h_oe[12]) mis++;
            for (int i = 0; i < 32; i++)
                if (!h_oe[13 + i] || h_o[13 + i] !== wd[i]) mis++;
            if (!h_oe[45] || h_o[45] !== ^wd) mis++;
            chk(mis == 0, "R7", "write phase bit errors", mis, 0);
        end else begin
            chk(h_oe[12] == 1'b0, "R8", "final turnaround drive", h_oe[12], 0);
        end
        chk(!swdio_oe && !swclk, "R7", "line released at done", {swdio_oe, swclk}, 0);
        chk(((t1 - t0) > (2.0 * eff * 5.0 - 0.1)) && ((t1 - t0) < (2.0 * eff * 5.0 + 0.1)),
            "R2", "swclk period ps", longint'((t1 - t0) * 1000), longint'(eff * 10000));
    endtask

    task automatic do_lreset(input logic [DIV_W-1:0] dv);
        clk_div = dv;
        issue(2'd1, 1'b0, 1'b0, 2'd0, 32'd0);
        wait_done("R9");
        chk(rcount == 50, "R9", "line reset clocks", rcount, 50);
        chk(h_oe[49:0] == {50{1'b1}} && h_o[49:0] == {50{1'b1}}, "R9",
            "line reset bits", h_o[49:0], {50{1'b1}});
    endtask

    task automatic do_switch(input logic [DIV_W-1:0] dv);
        clk_div = dv;
        issue(2'd2, 1'b0, 1'b0, 2'd0, 32'd0);
        wait_done("R10");
        chk(rcount == 16, "R10", "switch clocks", rcount, 16);
        chk(h_oe[15:0] == 16'hFFFF && h_o[15:0] == 16'hE79E, "R10",
            "switch pattern", h_o[15:0], 16'hE79E);
    endtask

    task automatic do_refuse(input logic [1:0] op, input logic ap, input logic rd,
                             input logic [1:0] a);
        issue(op, ap, rd, a, 32'hDEAD_BEEF);
        @(negedge clk);
        chk(!busy && rcount == 0, "R11", "refused command clocks", rcount, 0);
        chk(ack_code == 3'b000, "R11", "refused ack", ack_code, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) tgt[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !swclk && !swdio_oe, "R1", "control outputs in reset",
            {busy, done, swclk, swdio_oe}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !swclk && !swdio_oe && ack_code == 0 && !par_err && rd_data == 0,
            "R1", "state after reset", {busy, done, swclk, swdio_oe, ack_code, par_err}, 0);

        // R11: alignment guard after reset
        do_refuse(2'd0, 1'b0, 1'b0, 2'd1);
        do_refuse(2'd3, 1'b1, 1'b1, 2'd0);
        do_xfer(1'b0, 1'b1, 2'd0, 32'd0, 3'b001, 32'h2BA0_1477, 0, 8'd2);

        do_lreset(8'd1);
        do_switch(8'd3);
        do_lreset(8'd0);
        do_refuse(2'd0, 1'b1, 1'b1, 2'd3);   // R11 after line reset
        do_xfer(1'b0, 1'b1, 2'd0, 32'd0, 3'b001, 32'h0BB1_1477, 0, 8'd1);

        // directed corners
        do_xfer(1'b1, 1'b0, 2'd1, 32'h8000_0001, 3'b001, 32'd0, 0, 8'd1);  // R7
        do_xfer(1'b1, 1'b1, 2'd3, 32'd0, 3'b010, 32'd0, 0, 8'd4);          // R8 WAIT
        do_xfer(1'b0, 1'b0, 2'd2, 32'h1234_5678, 3'b100, 32'd0, 0, 8'd2);  // R8 FAULT
        do_xfer(1'b1, 1'b1, 2'd3, 32'd0, 3'b001, 32'hFFFF_FFFF, 1, 8'd1);  // R6 bad parity
        do_xfer(1'b1, 1'b1, 2'd0, 32'd0, 3'b001, 32'h0000_0000, 0, 8'd3);  // R6 clears
        do_xfer(1'b0, 1'b1, 2'd1, 32'd0, 3'b111, 32'h5555_5555, 0, 8'd1);  // R8 no target

        // R12: start during busy is ignored
        fork
            do_xfer(1'b1, 1'b0, 2'd2, 32'hA5A5_0F0F, 3'b001, 32'd0, 0, 8'd2);
            begin
                repeat (40) @(negedge clk);
                cmd_start = 1'b1;
                @(negedge clk);
                cmd_start = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(!busy && rcount == 46, "R12", "start while busy ignored", rcount, 46);

        for (int k = 0; k < 40; k++) begin
            logic [2:0] ak;
            int sel;
            sel = $urandom_range(0, 7);
            ak = (sel < 5) ? 3'b001 : (sel == 5) ? 3'b010 : (sel == 6) ? 3'b100 : 3'b111;
            do_xfer(1'($urandom), 1'($urandom), 2'($urandom), $urandom, ak, $urandom,
                    ($urandom_range(0, 3) == 0), DIV_W'($urandom_range(0, 4)));
        end
        summary();
    end
endmodule